// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Command Controller

This block lets a host run commands on a byte-organised serial EEPROM that has a chip select, a serial clock, and one data line in each direction. The host loads an 8-bit data register. It then writes a command made of a 3-bit operation code and a 7-bit address. The controller shifts the matching frame out to the EEPROM, collects read data, and waits for programming to finish by polling the device's ready level. The serial clock runs at the system clock divided by `2*CLK_DIV`.

The controller also runs a reload sequence. It reads a signature byte at address 0. If the signature is correct, it reads six more bytes into a 48-bit MAC address register. Three flags report the results: a timeout flag, a load-complete flag and a MAC-loaded flag.

Top module: `uwire_eeprom_ctl`

## Requirements
- R1: Host operation codes are 1=EWDS, 2=EWEN, 5=ERASE and 6=ERAL. Each of these sends exactly 10 serial clocks: a start bit 1, then two opcode bits, then seven address bits, MSB first. The opcode and address bits are:
  - EWDS: `00 0000000`
  - EWEN: `00 1100000`
  - ERASE: `11` followed by the address
  - ERAL: `00 1000000`
- R2: Host operation codes 0=READ, 3=WRITE and 4=WRAL each send exactly 18 serial clocks. The frame is the 10-bit header followed by data bits D7 to D0. The headers are:
  - READ: `1 10 addr`
  - WRITE: `1 01 addr`
  - WRAL: `1 00 0100000`
- R3: `ee_do` changes only while `ee_sk` is low. `ee_sk` stays low whenever `ee_cs` is low. Each serial clock phase lasts exactly `CLK_DIV` system clocks.
- R4: READ samples `ee_di` on rising serial clock edges 11 to 18 and stores the result in `data_reg`, first sample as the MSB. The dummy zero bit comes before edge 11 and is not stored.
- R5: `busy` rises on the cycle after an accepted `cmd_wr` and stays high until the operation has ended and chip select has been low for `CS_LOW_MIN` cycles. While `busy` is high, `cmd_wr` and `data_wr` are ignored.
- R6: WRITE, ERASE, ERAL and WRAL drop chip select after the last clock. Chip select is then raised again with no clocks to poll `ee_di`, where 0 means busy and 1 means ready. The operation ends on ready.
- R7: If `ee_di` stays 0 for `TIMEOUT_CYC` system clocks of polling, `timeout` is set and the operation ends. Any accepted command clears `timeout` and `load_done`.
- R8: Between any two chip select high periods, chip select stays low for at least `CS_LOW_MIN` system clocks.
- R9: Operation code 7 starts a reload, which first reads address 0. If that byte is not 0xA5, the reload ends after that single frame. In that case `mac_loaded` and `load_done` are 0 and `mac_addr` is unchanged.
- R10: A reload that finds 0xA5 reads addresses 1 to 6. The byte at address 1 goes to `mac_addr[7:0]` and the byte at address 6 goes to `mac_addr[47:40]`. At the end, `mac_loaded` and `load_done` are set.
- R11: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_op | input | 3 | Operation code |
| cmd_addr | input | 7 | EEPROM byte address |
| data_wr | input | 1 | Data register write strobe |
| data_in | input | 8 | Value for the data register |
| data_reg | output | 8 | Data register (write data, read result) |
| busy | output | 1 | Operation in progress |
| timeout | output | 1 | Ready poll timed out |
| load_done | output | 1 | Reload completed successfully |
| mac_loaded | output | 1 | MAC address register holds reloaded data |
| mac_addr | output | 48 | MAC address register |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_do | output | 1 | Serial data to EEPROM |
| ee_di | input | 1 | Serial data / ready level from EEPROM |

## Verification
The assertions check these properties on every cycle:
- the serial clock is gated by chip select, and data out is stable while the clock is high;
- every chip-select period holds exactly 0, 10 or 18 rising clocks;
- chip select is low for at least the minimum time before it rises again;
- chip select is low whenever the block is idle;
- the timeout flag can rise only during an operation, and a MAC load is always flagged as complete.

Other behaviour depends on a behavioural EEPROM model, so only the bench's scenarios can show it:
- the exact bit content of each frame;
- the read data capture;
- the poll that follows each programming command;
- the ignored writes during busy;
- the byte order of the reload and the failure on a bad signature.

// File: rtl/uwire_eeprom_ctl.sv
module uwire_eeprom_ctl #(
  parameter int CLK_DIV     = 8,
  parameter int CS_LOW_MIN  = 50,
  parameter int TIMEOUT_CYC = 3_750_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_wr,
  input  logic [2:0]  cmd_op,
  input  logic [6:0]  cmd_addr,
  input  logic        data_wr,
  input  logic [7:0]  data_in,
  output logic [7:0]  data_reg,
  output logic        busy,
  output logic        timeout,
  output logic        load_done,
  output logic        mac_loaded,
  output logic [47:0] mac_addr,
  output logic        ee_cs,
  output logic        ee_sk,
  output logic        ee_do,
  input  logic        ee_di
);
  localparam int DW = $clog2(CLK_DIV + 1);
  localparam int TW = $clog2(TIMEOUT_CYC + CS_LOW_MIN + CLK_DIV + 1);
  localparam logic [2:0] OP_READ = 3'd0, OP_EWDS = 3'd1, OP_EWEN = 3'd2, OP_WRITE = 3'd3,
                         OP_WRAL = 3'd4, OP_ERASE = 3'd5, OP_ERAL = 3'd6, OP_RELOAD = 3'd7;

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_GAP, S_POLL} st_t;
  st_t st;

  logic [DW-1:0] div;
  logic [TW-1:0] tmr;
  logic [17:0]   frame;
  logic [4:0]    bitn;
  logic          long_f, need_poll, rl_act;
  logic [2:0]    opr, rl_idx;
  logic [7:0]    rx;

  function automatic logic [17:0] mkframe(input logic [2:0] op, input logic [6:0] a,
                                          input logic [7:0] d);
    case (op)
      OP_READ, OP_RELOAD: mkframe = {3'b110, a, 8'h00};
      OP_WRITE:           mkframe = {3'b101, a, d};
      OP_ERASE:           mkframe = {3'b111, a, 8'h00};
      OP_WRAL:            mkframe = {3'b100, 7'b0100000, d};
      OP_ERAL:            mkframe = {3'b100, 7'b1000000, 8'h00};
      OP_EWEN:            mkframe = {3'b100, 7'b1100000, 8'h00};
      default:            mkframe = {3'b100, 7'b0000000, 8'h00};
    endcase
  endfunction

  logic       accept, gap_done, rl_next, launch, tick, last, poll_ok, poll_to;
  logic [2:0] l_op;
  logic [6:0] l_addr;
  logic [17:0] l_frame;

  assign busy     = (st != S_IDLE);
  assign accept   = (st == S_IDLE) && cmd_wr;
  assign gap_done = (st == S_GAP) && (tmr == TW'(CS_LOW_MIN - 1));
  assign rl_next  = gap_done && !need_poll && rl_act;
  assign launch   = accept || rl_next;
  assign l_op     = accept ? cmd_op : OP_READ;
  assign l_addr   = accept ? ((cmd_op == OP_RELOAD) ? 7'd0 : cmd_addr) : {4'd0, rl_idx};
  assign l_frame  = mkframe(l_op, l_addr, data_reg);
  assign tick     = (div == DW'(CLK_DIV - 1));
  assign last     = (st == S_SHIFT) && tick && ee_sk && (bitn == (long_f ? 5'd17 : 5'd9));
  assign poll_ok  = (st == S_POLL) && ee_di && (tmr >= TW'(CLK_DIV));
  assign poll_to  = (st == S_POLL) && (tmr == TW'(TIMEOUT_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;  div <= '0;  tmr <= '0;  frame <= '0;  bitn <= '0;
      long_f <= 1'b0;  need_poll <= 1'b0;  rl_act <= 1'b0;  opr <= '0;  rl_idx <= '0;
      rx <= '0;  data_reg <= '0;  timeout <= 1'b0;  load_done <= 1'b0;
      mac_loaded <= 1'b0;  mac_addr <= '0;  ee_cs <= 1'b0;  ee_sk <= 1'b0;  ee_do <= 1'b0;
    end else begin
      div <= (st == S_SHIFT && !tick && !launch) ? div + 1'b1 : '0;
      tmr <= ((st == S_GAP || st == S_POLL) && !gap_done && !poll_ok && !poll_to)
             ? tmr + 1'b1 : '0;

      if (data_wr && st == S_IDLE) data_reg <= data_in;

      if (accept) begin
        timeout   <= 1'b0;
        load_done <= 1'b0;
        opr       <= cmd_op;
        need_poll <= (cmd_op == OP_WRITE) || (cmd_op == OP_WRAL) ||
                     (cmd_op == OP_ERASE) || (cmd_op == OP_ERAL);
        rl_act    <= (cmd_op == OP_RELOAD);
        rl_idx    <= '0;
        if (cmd_op == OP_RELOAD) mac_loaded <= 1'b0;
      end

      if (launch) begin
        st     <= S_SHIFT;
        ee_cs  <= 1'b1;
        ee_sk  <= 1'b0;
        bitn   <= '0;
        frame  <= l_frame;
        ee_do  <= l_frame[17];
        long_f <= (l_op == OP_READ) || (l_op == OP_WRITE) ||
                  (l_op == OP_WRAL) || (l_op == OP_RELOAD);
      end else begin
        case (st)
          S_SHIFT: if (tick) begin
            if (!ee_sk) begin
              ee_sk <= 1'b1;
              if (bitn >= 5'd10) rx <= {rx[6:0], ee_di};
            end else begin
              ee_sk <= 1'b0;
              if (last) begin
                ee_cs <= 1'b0;
                ee_do <= 1'b0;
                st    <= S_GAP;
                if (rl_act) begin
                  if (rl_idx == 3'd0) begin
                    if (rx != 8'hA5) rl_act <= 1'b0;
                    else             rl_idx <= 3'd1;
                  end else begin
                    mac_addr[{rl_idx - 3'd1, 3'b000} +: 8] <= rx;
                    if (rl_idx == 3'd6) begin
                      rl_act     <= 1'b0;
                      mac_loaded <= 1'b1;
                      load_done  <= 1'b1;
                    end else rl_idx <= rl_idx + 3'd1;
                  end
                end else if (opr == OP_READ) data_reg <= rx;
              end else begin
                bitn  <= bitn + 5'd1;
                ee_do <= frame[5'd16 - bitn];
              end
            end
          end
          S_GAP: if (gap_done) begin
            if (need_poll) begin
              st        <= S_POLL;
              ee_cs     <= 1'b1;
              need_poll <= 1'b0;
            end else st <= S_IDLE;
          end
          S_POLL: if (poll_ok || poll_to) begin
            ee_cs <= 1'b0;
            st    <= S_GAP;
            if (!poll_ok) timeout <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/uwire_eeprom_ctl_chk.sv
module uwire_eeprom_ctl_chk #(
  parameter int CS_LOW_MIN = 50
) (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic timeout,
  input logic load_done,
  input logic mac_loaded,
  input logic ee_cs,
  input logic ee_sk,
  input logic ee_do
);
  localparam int CW = $clog2(CS_LOW_MIN + 1);
  logic [4:0]    rises;
  logic          sk_q;
  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rises   <= '0;
      sk_q    <= 1'b0;
      low_cnt <= CW'(CS_LOW_MIN);
    end else begin
      sk_q <= ee_sk;
      if (!ee_cs) rises <= '0;
      else if (ee_sk && !sk_q) rises <= rises + 5'd1;
      if (ee_cs) low_cnt <= '0;
      else if (low_cnt < CW'(CS_LOW_MIN)) low_cnt <= low_cnt + 1'b1;
    end
  end

  assert_sk_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ee_cs |-> !ee_sk);
  assert_do_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ee_sk |-> $stable(ee_do));
  // R1 and R2: a select period carries 0 (poll), 10 or 18 clocks
  assert_frame_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ee_cs) |-> (rises == 5'd0 || rises == 5'd10 || rises == 5'd18));
  assert_cs_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ee_cs) |-> (low_cnt >= CW'(CS_LOW_MIN)));
  assert_idle_cs_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !ee_cs);
  assert_timeout_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout) |-> busy);
  assert_loaded_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mac_loaded) |-> load_done);
endmodule

bind uwire_eeprom_ctl uwire_eeprom_ctl_chk #(.CS_LOW_MIN(CS_LOW_MIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .timeout(timeout), .load_done(load_done),
  .mac_loaded(mac_loaded), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_do(ee_do)
);

// File: tb/sim_uwire_eeprom_ctl.sv
module sim_uwire_eeprom_ctl;
  localparam int CLK_DIV = 4, CS_LOW_MIN = 6, TIMEOUT_CYC = 3000, PROG_CYC = 300;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, cmd_wr, data_wr, busy, timeout, load_done, mac_loaded;
  logic ee_cs, ee_sk, ee_do, ee_di;
  logic [2:0] cmd_op;
  logic [6:0] cmd_addr;
  logic [7:0] data_in, data_reg;
  logic [47:0] mac_addr;

  uwire_eeprom_ctl #(.CLK_DIV(CLK_DIV), .CS_LOW_MIN(CS_LOW_MIN), .TIMEOUT_CYC(TIMEOUT_CYC)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .data_wr(data_wr), .data_in(data_in), .data_reg(data_reg), .busy(busy),
    .timeout(timeout), .load_done(load_done), .mac_loaded(mac_loaded), .mac_addr(mac_addr),
    .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_do(ee_do), .ee_di(ee_di));

  // behavioural EEPROM
  logic [7:0]  mem [128];
  logic        ewen, stuck, di_r, sk_q, cs_q, poke_en;
  logic [6:0]  poke_a;
  logic [7:0]  poke_v, rd_l;
  logic [17:0] sr, last_sr;
  int          bc, prog_cnt, nfr, last_bc;

  assign ee_di = ee_cs && ((bc == 0) ? (prog_cnt == 0 && !stuck) : di_r);

  always @(posedge clk) begin : model
    logic [1:0] o;
    logic [6:0] a;
    logic [7:0] d, b;
    if (!rst_n) begin
      ewen <= 1'b0; di_r <= 1'b0; sk_q <= 1'b0; cs_q <= 1'b0; sr <= '0; last_sr <= '0;
      bc <= 0; prog_cnt <= 0; nfr <= 0; last_bc <= 0; rd_l <= '0;
      for (int i = 0; i < 128; i++) mem[i] <= 8'hFF;
    end else begin
      sk_q <= ee_sk;
      cs_q <= ee_cs;
      if (prog_cnt > 0) prog_cnt <= prog_cnt - 1;
      if (poke_en) mem[poke_a] <= poke_v;
      if (ee_cs && ee_sk && !sk_q) begin
        sr <= {sr[16:0], ee_do};
        bc <= bc + 1;
      end
      if (ee_cs && !ee_sk && sk_q && bc >= 10 && bc <= 17) begin
        b = (bc == 10) ? mem[sr[6:0]] : rd_l;
        rd_l <= b;
        di_r <= b[17 - bc];
      end
      if (!ee_cs && cs_q) begin
        bc <= 0;
        if (bc != 0) begin
          nfr <= nfr + 1; last_bc <= bc; last_sr <= sr;
          if (bc == 18) begin o = sr[16:15]; a = sr[14:8]; d = sr[7:0]; end
          else begin o = sr[8:7]; a = sr[6:0]; d = 8'h00; end
          case (o)
            2'b00: case (a[6:5])
              2'b11: ewen <= 1'b1;
              2'b00: ewen <= 1'b0;
              2'b10: if (ewen) begin for (int i = 0; i < 128; i++) mem[i] <= 8'hFF; prog_cnt <= PROG_CYC; end
              default: if (ewen) begin for (int i = 0; i < 128; i++) mem[i] <= d; prog_cnt <= PROG_CYC; end
            endcase
            2'b01: if (ewen) begin mem[a] <= d; prog_cnt <= PROG_CYC; end
            2'b11: if (ewen) begin mem[a] <= 8'hFF; prog_cnt <= PROG_CYC; end
            default: ;
          endcase
        end
      end
    end
  end

  // pin monitors
  int rises = 0, low_run = 0, min_low = 1000, hi_run = 0, pin_bad = 0;
  logic cs_p = 1'b0, sk_p = 1'b0, do_p = 1'b0, seen = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (ee_cs && !cs_p) begin
        rises++;
        if (seen && low_run < min_low) min_low = low_run;
        seen = 1'b1;
      end
      low_run = ee_cs ? 0 : low_run + 1;
      if (ee_sk) hi_run++;
      else begin
        if (hi_run != 0 && hi_run != CLK_DIV) pin_bad++;
        hi_run = 0;
      end
      if (ee_sk && sk_p && ee_do != do_p) pin_bad++;
      if (ee_sk && !ee_cs) pin_bad++;
    end
    cs_p = ee_cs; sk_p = ee_sk; do_p = ee_do;
  end

  int n_chk = 0, n_fail = 0;
  logic done = 1'b0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [17:0] expf(input logic [2:0] op, input logic [6:0] a,
                                       input logic [7:0] d);
    case (op)
      3'd0: expf = {1'b1, 2'b10, a, 8'h00};
      3'd1: expf = {1'b1, 2'b00, 7'b0000000, 8'h00};
      3'd2: expf = {1'b1, 2'b00, 7'b1100000, 8'h00};
      3'd3: expf = {1'b1, 2'b01, a, d};
      3'd4: expf = {1'b1, 2'b00, 7'b0100000, d};
      3'd5: expf = {1'b1, 2'b11, a, 8'h00};
      default: expf = {1'b1, 2'b00, 7'b1000000, 8'h00};
    endcase
  endfunction

  task automatic set_data(input logic [7:0] v);
    @(negedge clk); data_in = v; data_wr = 1'b1;
    @(negedge clk); data_wr = 1'b0;
  endtask

  task automatic issue(input logic [2:0] op, input logic [6:0] a);
    @(negedge clk); cmd_op = op; cmd_addr = a; cmd_wr = 1'b1;
    @(negedge clk); cmd_wr = 1'b0;
  endtask

  task automatic wait_idle(output int cyc);
    cyc = 0;
    while (busy && cyc < 50000) begin @(negedge clk); cyc++; end
  endtask

  task automatic poke(input logic [6:0] a, input logic [7:0] v);
    @(negedge clk); poke_a = a; poke_v = v; poke_en = 1'b1;
    @(negedge clk); poke_en = 1'b0;
  endtask

  typedef struct packed {
    logic [2:0] op; logic [6:0] a; logic [7:0] d; logic [4:0] nb;
    logic [1:0] rs; logic chk; logic [7:0] rd;
  } vec_t;

  localparam vec_t VEC [12] = '{
    '{3'd2, 7'd0,   8'h00, 5'd10, 2'd1, 1'b0, 8'h00},
    '{3'd3, 7'd5,   8'h3C, 5'd18, 2'd2, 1'b0, 8'h00},
    '{3'd0, 7'd5,   8'h00, 5'd18, 2'd1, 1'b1, 8'h3C},
    '{3'd5, 7'd5,   8'h00, 5'd10, 2'd2, 1'b0, 8'h00},
    '{3'd0, 7'd5,   8'h00, 5'd18, 2'd1, 1'b1, 8'hFF},
    '{3'd4, 7'd0,   8'h5A, 5'd18, 2'd2, 1'b0, 8'h00},
    '{3'd0, 7'd100, 8'h00, 5'd18, 2'd1, 1'b1, 8'h5A},
    '{3'd6, 7'd0,   8'h00, 5'd10, 2'd2, 1'b0, 8'h00},
    '{3'd0, 7'd100, 8'h00, 5'd18, 2'd1, 1'b1, 8'hFF},
    '{3'd1, 7'd0,   8'h00, 5'd10, 2'd1, 1'b0, 8'h00},
    '{3'd3, 7'd2,   8'h11, 5'd18, 2'd2, 1'b0, 8'h00},
    '{3'd0, 7'd2,   8'h00, 5'd18, 2'd1, 1'b1, 8'hFF}
  };

  initial begin
    int f0, r0, cyc;
    logic [17:0] ef;
    rst_n = 1'b0; cmd_wr = 1'b0; cmd_op = '0; cmd_addr = '0; data_wr = 1'b0; data_in = '0;
    stuck = 1'b0; poke_en = 1'b0; poke_a = '0; poke_v = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 reset outputs",
        {data_reg, busy, timeout, load_done, mac_loaded, ee_cs, ee_sk, ee_do}, '0);
    chk("R11 reset mac", mac_addr, '0);

    for (int i = 0; i < 12; i++) begin
      set_data(VEC[i].d);
      f0 = nfr; r0 = rises;
      issue(VEC[i].op, VEC[i].a);
      wait_idle(cyc);
      ef = expf(VEC[i].op, VEC[i].a, VEC[i].d);
      if (VEC[i].nb == 5'd10) begin
        chk("R1 clock count", last_bc, 10);
        chk("R1 frame bits", last_sr[9:0], ef[17:8]);
      end else begin
        chk("R2 clock count", last_bc, 18);
        chk("R2 frame bits", last_sr, ef);
      end
      chk("R6 select periods", rises - r0, VEC[i].rs);
      chk("R5 one frame per command", nfr - f0, 1);
      if (VEC[i].chk) chk("R4 read data", data_reg, VEC[i].rd);
    end

    set_data(8'h77);
    f0 = nfr; r0 = rises;
    issue(3'd5, 7'd9);
    repeat (3) @(negedge clk);
    data_in = 8'h12; data_wr = 1'b1; cmd_op = 3'd0; cmd_addr = 7'd1; cmd_wr = 1'b1;
    @(negedge clk); data_wr = 1'b0; cmd_wr = 1'b0;
    wait_idle(cyc);
    chk("R5 busy write ignored frames", nfr - f0, 1);
    chk("R5 busy write ignored data", data_reg, 8'h77);
    chk("R5 erase frame kept", last_sr[9:0], {3'b111, 7'd9});

    issue(3'd2, 7'd0);
    wait_idle(cyc);
    stuck = 1'b1;
    set_data(8'hAA);
    issue(3'd3, 7'd7);
    wait_idle(cyc);
    chk("R7 timeout flag", timeout, 1'b1);
    chk("R7 busy length", (cyc >= TIMEOUT_CYC) && (cyc < TIMEOUT_CYC + 200), 1'b1);
    stuck = 1'b0;
    issue(3'd1, 7'd0);
    wait_idle(cyc);
    chk("R7 timeout cleared", timeout, 1'b0);

    f0 = nfr;
    issue(3'd7, 7'd0);
    wait_idle(cyc);
    chk("R9 fail single frame", nfr - f0, 1);
    chk("R9 fail flags", {mac_loaded, load_done}, 2'b00);
    chk("R9 mac unchanged", mac_addr, '0);

    poke(7'd0, 8'hA5);
    for (int k = 1; k <= 6; k++) poke(7'(k), 8'(k * 8'h11));
    f0 = nfr;
    issue(3'd7, 7'd0);
    wait_idle(cyc);
    chk("R10 frames", nfr - f0, 7);
    chk("R10 mac order", mac_addr, 48'h665544332211);
    chk("R10 flags", {mac_loaded, load_done}, 2'b11);

    poke(7'd0, 8'h00);
    issue(3'd7, 7'd0);
    wait_idle(cyc);
    chk("R9 refail flags", {mac_loaded, load_done}, 2'b00);
    chk("R9 refail mac kept", mac_addr, 48'h665544332211);

    chk("R3 pin timing", pin_bad, 0);
    chk("R8 min select gap", min_low >= CS_LOW_MIN, 1'b1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule